// File: doc/BRIEF.md
# Block Memory Copy Engine

This block moves a run of bytes from one place in a byte-wide memory to another. A processor hands it three values taken from its registers: a byte count, a source pointer and a destination pointer. It then pulses a start strobe. The engine walks both regions in ascending address order. For each byte it uses one read cycle at the source pointer and then one write cycle at the destination pointer. The memory port is single-ported, so only one access is made in any cycle.

While the engine works, `busy` stays high, and the processor holds back its next instruction until the copy ends. At the end the engine asserts `done` for one cycle, together with a register write enable. During that cycle it presents the advanced pointers and a count of zero, so that the processor can write them back into its registers. A count of zero moves nothing: the engine finishes one cycle after the start. Pointers wrap within the address space. Nothing is done about overlapping regions, so a forward copy into a region that overlaps the source sees bytes it has already written.

The controller has four named states. IDLE waits for a start. FETCH drives the source address with a read strobe. STORE drives the destination address with a write strobe and the byte the memory returned, and it steps the pointers and the count. WRAPUP raises `done` and the write-back enable. The transitions are named as follows:
- IDLE→FETCH is a start with a nonzero count.
- IDLE→WRAPUP is a start with a zero count.
- FETCH→STORE always happens.
- STORE→FETCH happens when bytes remain.
- STORE→WRAPUP happens after the last byte.
- WRAPUP→IDLE always happens.

Top module: `blk_copy_engine`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `done`, `wb_en`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: A start sampled while idle makes `busy` high from the next cycle. `busy` stays high through the cycle in which `done` is high and is low in the cycle after.
- R3: Each byte takes a read cycle (`mem_rd_en`=1, `mem_addr`=source pointer), followed in the next cycle by a write cycle (`mem_wr_en`=1, `mem_addr`=destination pointer). In the write cycle, `mem_wdata` equals the byte the memory returns on `mem_rdata` one cycle after the read strobe.
- R4: Bytes are copied in ascending order. After each write, both pointers advance by one and the count drops by one. Exactly `cnt_in` bytes are copied.
- R5: With `cnt_in`=0, no memory access occurs, and `done` rises one cycle after the start with the pointers unchanged.
- R6: Pointers wrap from the top address (all ones) to address 0.
- R7: `done` and `wb_en` are single-cycle pulses. They are high together, with `cnt_out`=0, `src_out`=start source + count and `dst_out`=start destination + count, each taken modulo the address space.
- R8: A start strobe while `busy` is high is ignored and does not change the copy in progress.
- R9: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.
- R10: A destination overlapping the source at a higher address is copied forward with no correction. With destination = source + 1, every destination byte takes the value of the first source byte.
- R11: The maximum count of 255 copies 255 bytes in 511 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled only while idle |
| cnt_in | input | 8 | Byte count to copy |
| src_in | input | 16 | Starting source pointer |
| dst_in | input | 16 | Starting destination pointer |
| busy | output | 1 | High from the cycle after the start until the end of the copy |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register write-back enable for the outputs below |
| cnt_out | output | 8 | Final count (zero) |
| src_out | output | 16 | Advanced source pointer |
| dst_out | output | 16 | Advanced destination pointer |
| mem_addr | output | 16 | Memory address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the read strobe |

## Verification
The bench builds the engine with its default widths: a 16-bit address and an 8-bit count. With those widths a copy that starts a few bytes below the all-ones address is enough to show the pointer wrap, and the longest possible copy of 255 bytes fits easily in one run. Driving a second start in the middle of a copy, and copying with the destination one byte above the source, show that a mid-copy start has no effect and that an overlapping forward copy replicates the first source byte.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_STORE  = 2'd2,
        ST_WRAPUP = 2'd3
    } cpy_state_e;

endpackage

// File: rtl/blkcpy_fsm.sv
module blkcpy_fsm
    import blkcpy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       load_zero,
    input  logic       last_byte,
    output cpy_state_e state,
    output logic       load,
    output logic       step,
    output logic       rd_en,
    output logic       wr_en,
    output logic       busy,
    output logic       done
);

    cpy_state_e state_q;
    cpy_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = load_zero ? ST_WRAPUP : ST_FETCH;
                end
            end
            ST_FETCH:  state_d = ST_STORE;
            ST_STORE:  state_d = last_byte ? ST_WRAPUP : ST_FETCH;
            ST_WRAPUP: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        load  = 1'b0;
        step  = 1'b0;
        rd_en = 1'b0;
        wr_en = 1'b0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_FETCH: begin
                rd_en = 1'b1;
            end
            ST_STORE: begin
                wr_en = 1'b1;
                step  = 1'b1;
            end
            ST_WRAPUP: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/blkcpy_ptr.sv
module blkcpy_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] init,
    output logic [ADDR_W-1:0] value
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] ptr_q;

    // increment is modulo 2**ADDR_W, which gives the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= init;
        end else if (step) begin
            ptr_q <= ptr_q + ONE;
        end
    end

    assign value = ptr_q;

endmodule

// File: rtl/blkcpy_count.sv
module blkcpy_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] init,
    output logic [CNT_W-1:0] value,
    output logic             init_zero,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= init;
        end else if (step) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign value     = cnt_q;
    assign init_zero = (init == '0);
    assign last      = (cnt_q == ONE);

endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
    import blkcpy_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    output logic              busy,
    output logic              done,
    output logic              wb_en,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [ADDR_W-1:0] src_out,
    output logic [ADDR_W-1:0] dst_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int NPTR = 2;  // index 0 source, index 1 destination

    cpy_state_e        state;
    logic              load;
    logic              step;
    logic              load_zero;
    logic              last_byte;
    logic [CNT_W-1:0]  cnt_val;
    logic [ADDR_W-1:0] ptr_init [NPTR];
    logic [ADDR_W-1:0] ptr_val  [NPTR];

    blkcpy_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_zero (load_zero),
        .last_byte (last_byte),
        .state     (state),
        .load      (load),
        .step      (step),
        .rd_en     (mem_rd_en),
        .wr_en     (mem_wr_en),
        .busy      (busy),
        .done      (done)
    );

    blkcpy_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .init      (cnt_in),
        .value     (cnt_val),
        .init_zero (load_zero),
        .last      (last_byte)
    );

    assign ptr_init[0] = src_in;
    assign ptr_init[1] = dst_in;

    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        blkcpy_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .step  (step),
            .init  (ptr_init[gi]),
            .value (ptr_val[gi])
        );
    end

    // a write cycle addresses the destination, every other cycle the source
    assign mem_addr  = (state == ST_STORE) ? ptr_val[1] : ptr_val[0];
    assign mem_wdata = mem_rdata;

    assign wb_en   = done;
    assign cnt_out = cnt_val;
    assign src_out = ptr_val[0];
    assign dst_out = ptr_val[1];

endmodule

// File: rtl/blkcpy_checker.sv
module blkcpy_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              wb_en,
    input logic [CNT_W-1:0]  cnt_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic              mem_wr_en
);

    assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en, 2)) |-> (mem_addr == $past(mem_addr, 2) + ADDR_W'(1)));

    assert_done_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wb_en && cnt_out == '0));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

bind blk_copy_engine blkcpy_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .wb_en     (wb_en),
    .cnt_out   (cnt_out),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en)
);

// File: tb/tb_blk_copy_engine.sv
module tb_blk_copy_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cnt_in = '0;
    logic [15:0] src_in = '0;
    logic [15:0] dst_in = '0;
    logic        busy, done, wb_en;
    logic [7:0]  cnt_out;
    logic [15:0] src_out, dst_out, mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    string scen = "R1";

    always #10 clk = ~clk;

    blk_copy_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_in),
        .src_in(src_in), .dst_in(dst_in), .busy(busy), .done(done),
        .wb_en(wb_en), .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // bus memory and model memory
    logic [7:0] mem     [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] rd_bus(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction
    function automatic logic [7:0] rd_ref(int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= rd_bus(int'(mem_addr));
        if (mem_wr_en) mem[int'(mem_addr)] = mem_wdata;
    end

    // behavioural model: phase 0 idle, 1 read, 2 write, 3 finished
    int m_phase = 0;
    int m_src = 0, m_dst = 0, m_cnt = 0;
    int busy_cycles = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_src = int'(src_in); m_dst = int'(dst_in); m_cnt = int'(cnt_in);
                    m_phase = (m_cnt == 0) ? 3 : 1;
                end
                1: m_phase = 2;
                2: begin
                    ref_mem[m_dst] = rd_ref(m_src);
                    m_src = (m_src + 1) & 16'hFFFF;
                    m_dst = (m_dst + 1) & 16'hFFFF;
                    m_cnt = m_cnt - 1;
                    m_phase = (m_cnt == 0) ? 3 : 1;
                end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s]: actual %0h expected %0h", req, scen, act, exp);
        end
    endtask

    // per-cycle comparison away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cycles++;
            check("R2 busy", int'(busy), int'(m_phase != 0));
            check("R7 done", int'(done), int'(m_phase == 3));
            check("R7 wb_en", int'(wb_en), int'(m_phase == 3));
            check("R3 rd_en", int'(mem_rd_en), int'(m_phase == 1));
            check("R3 wr_en", int'(mem_wr_en), int'(m_phase == 2));
            check("R9 one access", int'(mem_rd_en && mem_wr_en), 0);
            if (m_phase == 1) check("R4 read addr", int'(mem_addr), m_src);
            if (m_phase == 2) begin
                check("R4 write addr", int'(mem_addr), m_dst);
                check("R3 wdata", int'(mem_wdata), int'(rd_ref(m_src)));
            end
            if (m_phase == 3) begin
                check("R7 cnt_out", int'(cnt_out), 0);
                check("R7 src_out", int'(src_out), m_src);
                check("R7 dst_out", int'(dst_out), m_dst);
            end
        end
    end

    task automatic fill(int base, int n, int seed);
        for (int i = 0; i < n; i++) begin
            int a = (base + i) & 16'hFFFF;
            mem[a] = 8'((seed + i * 7) ^ 8'h5A);
            ref_mem[a] = mem[a];
        end
    endtask

    // runs one copy; optional restart while busy
    task automatic run_copy(int n, int s, int d, bit poke);
        int guard = 0;
        busy_cycles = 0;
        @(negedge clk);
        cnt_in = 8'(n); src_in = 16'(s); dst_in = 16'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            cnt_in = 8'd3; src_in = 16'h7000; dst_in = 16'h7100; start = 1'b1; // R8
            @(negedge clk);
            start = 1'b0;
        end
        while (m_phase != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) check("watchdog", 1, 0);
        for (int i = 0; i < n; i++) begin
            int a = (d + i) & 16'hFFFF;
            check("R4 memory", int'(rd_bus(a)), int'(rd_ref(a)));
        end
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 access", int'(mem_rd_en | mem_wr_en | wb_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(busy | done | mem_rd_en | mem_wr_en), 0);

        scen = "R4 basic";
        fill(16'h0100, 5, 1);
        run_copy(5, 16'h0100, 16'h0200, 1'b0);
        check("R2 busy length", busy_cycles, 11);

        scen = "R5 zero count";
        run_copy(0, 16'h1234, 16'h4321, 1'b0);
        check("R5 busy length", busy_cycles, 1);

        scen = "R6 wrap";
        fill(16'hFFFD, 6, 9);
        run_copy(6, 16'hFFFD, 16'h8000, 1'b0);
        fill(16'h3000, 4, 3);
        run_copy(4, 16'h3000, 16'hFFFE, 1'b0);

        scen = "R8 restart ignored";
        fill(16'h0500, 8, 17);
        run_copy(8, 16'h0500, 16'h0600, 1'b1);
        check("R8 no stray write", int'(rd_bus(16'h7100)), 0);

        scen = "R10 overlap";
        fill(16'h0900, 5, 33);
        run_copy(4, 16'h0900, 16'h0901, 1'b0);
        for (int i = 1; i <= 4; i++)
            check("R10 replicate", int'(rd_bus(16'h0900 + i)), int'(rd_bus(16'h0900)));

        scen = "R11 max count";
        fill(16'h2000, 255, 77);
        run_copy(255, 16'h2000, 16'h4000, 1'b0);
        check("R11 busy length", busy_cycles, 511);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule